// File: doc/BRIEF.md
# Double-Buffered Octal Converter Register Bank

This block holds the digital state behind an eight-channel voltage converter. Each channel has a staging (input) register and an active (output) register. Group-wide settings for the output amplifier gain, reference buffering and supply-as-reference selection are held the same way. A per-channel power-down mask is also kept here. Decoded command strobes arrive from a separate frame receiver. The block then decides when staged values move into the active registers.

A transfer from staging to active happens on a load event. A load event occurs when the synchronized external active-low load pin is low, when the programmed load mode is transparent, or on the single cycle after a one-shot mode command. A transfer copies only the channels whose staging register has been written since their last transfer. The configuration settings move to active on every load event. When a group uses the supply as its reference, that group reports unbuffered operation at unity gain, whatever its other bits say.

Top module: `octal_dbl_bank`

## Requirements
- R1: A data write (`dat_wr`) loads only the staging register selected by `dat_sel`. No active code changes unless a load event occurs in that cycle. Channel i appears on `code_out[i*DW +: DW]`.
- R2: The load pin `load_n` passes through two synchronizing flops. If it goes low just before clock edge k, the first transfer from it happens at edge k+2. Transfers continue at every edge while it stays low.
- R3: Load mode encodings on `mode_val` are: 00 transparent (a load event every cycle), 01 latched, and 10 one-shot. A one-shot command gives exactly one load event, on the edge after the command, and then behaves as latched. Code 11 is ignored and leaves the mode unchanged.
- R4: A channel copies on a load event only if it has been written since its last transfer. A write in the same cycle as a load event is stored first. It transfers at the next load event, which in transparent mode is the next edge.
- R5: Gain (`cfg_gain`), buffer (`cfg_buf`) and supply-reference (`cfg_sup`) settings are staged by `cfg_wr`. They reach the effective outputs only on a load event. Bit g of each field belongs to group g, and group 0 covers channels 0 to 3.
- R6: For a group with the active supply-reference bit set, `eff_gain` and `eff_buf` read 0 for that group.
- R7: `pd_wr` loads `pd_val` into `pd_out` at the next edge. Bit i of `pd_out` is channel i. Data writes and transfers still work on a powered-down channel.
- R8: `clr_data` zeroes every staging and active code and clears all pending marks. Configuration, mode and power-down state are left unchanged.
- R9: `clr_all` and power-on reset zero all codes and settings, clear the power-down mask, and select latched mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| load_n | input | 1 | External asynchronous active-low load pin |
| dat_wr | input | 1 | Data write strobe |
| dat_sel | input | SW | Channel selected by the data write |
| dat_val | input | DW | Code for the data write |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_gain | input | NGRP | Per-group double-range gain bits |
| cfg_buf | input | NGRP | Per-group reference buffer bits |
| cfg_sup | input | NGRP | Per-group supply-as-reference bits |
| mode_wr | input | 1 | Load-mode write strobe |
| mode_val | input | 2 | Load-mode code |
| pd_wr | input | 1 | Power-down write strobe |
| pd_val | input | NCH | Power-down mask |
| clr_data | input | 1 | Data reset strobe |
| clr_all | input | 1 | Data and control reset strobe |
| code_out | output | NCH*DW | Active codes, channel i at bits i*DW upward |
| eff_gain | output | NGRP | Effective gain per group |
| eff_buf | output | NGRP | Effective buffer setting per group |
| eff_sup | output | NGRP | Effective supply-reference setting per group |
| pd_out | output | NCH | Active power-down mask |

## Verification
The hardest case to reach is a write and a load event that land on the same edge. This matters because the pending mark has to survive that edge while the transfer consumes the older value. The bench sets this up by holding the load pin low so that a load event is present in every cycle. It then writes a channel and checks the output on the edge after the write, where the old code must remain, and on the edge after that, where the new code must appear. The one-shot mode is also checked at its boundary: exactly one transfer follows the command, and the next staged write must stay invisible.

// File: rtl/octal_dbl_bank.sv
module octal_dbl_bank #(
  parameter int NCH  = 8,
  parameter int DW   = 12,
  parameter int NGRP = 2,
  parameter int SW   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              dat_wr,
  input  logic [SW-1:0]     dat_sel,
  input  logic [DW-1:0]     dat_val,
  input  logic              cfg_wr,
  input  logic [NGRP-1:0]   cfg_gain,
  input  logic [NGRP-1:0]   cfg_buf,
  input  logic [NGRP-1:0]   cfg_sup,
  input  logic              mode_wr,
  input  logic [1:0]        mode_val,
  input  logic              pd_wr,
  input  logic [NCH-1:0]    pd_val,
  input  logic              clr_data,
  input  logic              clr_all,
  output logic [NCH*DW-1:0] code_out,
  output logic [NGRP-1:0]   eff_gain,
  output logic [NGRP-1:0]   eff_buf,
  output logic [NGRP-1:0]   eff_sup,
  output logic [NCH-1:0]    pd_out
);

  localparam logic [1:0] M_TRANSP = 2'b00;
  localparam logic [1:0] M_LATCH  = 2'b01;
  localparam logic [1:0] M_SHOT   = 2'b10;
  localparam logic [1:0] M_RSVD   = 2'b11;
  localparam int CW = 3*NGRP;

  logic [DW-1:0]  stg_q [NCH];
  logic [DW-1:0]  act_q [NCH];
  logic [NCH-1:0] pend_q, wr_hot;
  logic [CW-1:0]  cfg_stg_q, cfg_act_q;
  logic [1:0]     mode_q, ld_sync_q;
  logic           shot_q, ld_evt, clr_any;
  logic [NGRP-1:0] act_gain, act_buf, act_sup;

  assign ld_evt  = ~ld_sync_q[1] | (mode_q == M_TRANSP) | shot_q;
  assign clr_any = clr_data | clr_all;
  assign wr_hot  = dat_wr ? ({{(NCH-1){1'b0}}, 1'b1} << dat_sel) : '0;

  assign {act_sup, act_buf, act_gain} = cfg_act_q;
  assign eff_sup  = act_sup;
  assign eff_gain = act_gain & ~act_sup;
  assign eff_buf  = act_buf & ~act_sup;

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign code_out[i*DW +: DW] = act_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_sync_q <= 2'b11;
      for (int i = 0; i < NCH; i++) begin
        stg_q[i] <= '0;
        act_q[i] <= '0;
      end
      pend_q    <= '0;
      cfg_stg_q <= '0;
      cfg_act_q <= '0;
      mode_q    <= M_LATCH;
      shot_q    <= 1'b0;
      pd_out    <= '0;
    end else begin
      ld_sync_q <= {ld_sync_q[0], load_n};
      if (clr_any) begin
        for (int i = 0; i < NCH; i++) begin
          stg_q[i] <= '0;
          act_q[i] <= '0;
        end
        pend_q <= '0;
      end else begin
        for (int i = 0; i < NCH; i++)
          if (ld_evt && pend_q[i]) act_q[i] <= stg_q[i];
        if (dat_wr) stg_q[dat_sel] <= dat_val;
        pend_q <= (pend_q & ~{NCH{ld_evt}}) | wr_hot;
      end
      if (clr_all) begin
        cfg_stg_q <= '0;
        cfg_act_q <= '0;
        mode_q    <= M_LATCH;
        shot_q    <= 1'b0;
        pd_out    <= '0;
      end else begin
        if (cfg_wr) cfg_stg_q <= {cfg_sup, cfg_buf, cfg_gain};
        if (ld_evt) cfg_act_q <= cfg_stg_q;
        shot_q <= 1'b0;
        if (mode_wr && mode_val != M_RSVD) begin
          if (mode_val == M_SHOT) begin
            mode_q <= M_LATCH;
            shot_q <= 1'b1;
          end else begin
            mode_q <= mode_val;
          end
        end
        if (pd_wr) pd_out <= pd_val;
      end
    end
  end

  assert_hold_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_evt && !clr_any) |=> $stable(code_out));

  assert_one_shot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shot_q |=> (!shot_q && mode_q != M_TRANSP));

  assert_reserved_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val == M_RSVD && !clr_all) |=> $stable(mode_q));

  assert_pend_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_evt && !dat_wr) |=> (pend_q == '0));

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_evt && !clr_all) |=> ($stable(eff_gain) && $stable(eff_buf) && $stable(eff_sup)));

  assert_data_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_data |=> (code_out == '0));

  assert_full_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (pd_out == '0 && eff_sup == '0 && mode_q == M_LATCH));

endmodule

// File: tb/octal_dbl_bank_tb_top.sv
module octal_dbl_bank_tb_top;
  localparam int NCH = 8, DW = 12, NGRP = 2, SW = 3;

  logic clk = 0, rst_n = 0, load_n = 1;
  logic dat_wr = 0, cfg_wr = 0, mode_wr = 0, pd_wr = 0, clr_data = 0, clr_all = 0;
  logic [SW-1:0] dat_sel = '0;
  logic [DW-1:0] dat_val = '0;
  logic [NGRP-1:0] cfg_gain = '0, cfg_buf = '0, cfg_sup = '0;
  logic [1:0] mode_val = '0;
  logic [NCH-1:0] pd_val = '0;
  logic [NCH*DW-1:0] code_out;
  logic [NGRP-1:0] eff_gain, eff_buf, eff_sup;
  logic [NCH-1:0] pd_out;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] exp_c [NCH];

  always #4 clk = ~clk;

  octal_dbl_bank #(.NCH(NCH), .DW(DW), .NGRP(NGRP)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_codes(input string req);
    logic [NCH*DW-1:0] e;
    for (int i = 0; i < NCH; i++) e[i*DW +: DW] = exp_c[i];
    chk(code_out === e, req, code_out, e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_dat(input int ch, input logic [DW-1:0] v);
    dat_wr = 1; dat_sel = SW'(ch); dat_val = v; tick(1); dat_wr = 0;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_wr = 1; mode_val = m; tick(1); mode_wr = 0;
  endtask

  task automatic wr_cfg(input logic [NGRP-1:0] g, b, s);
    cfg_wr = 1; cfg_gain = g; cfg_buf = b; cfg_sup = s; tick(1); cfg_wr = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int ch, input int k);
    return DW'((ch * 613 + k * 1291 + 7) % 4096);
  endfunction

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) exp_c[i] = '0;
    tick(2); rst_n = 1; tick(2);
    // R9 power-on state
    chk_codes("R9 reset codes");
    chk({eff_gain, eff_buf, eff_sup, pd_out} == '0, "R9 reset control", {eff_gain, eff_buf, eff_sup, pd_out}, 0);

    // R1 latched: writes do not reach outputs
    for (int i = 0; i < NCH; i++) wr_dat(i, pat(i, 0));
    tick(4);
    chk_codes("R1 latched hold");

    // R2 pin low: no transfer at edge k+1, transfer at edge k+2
    load_n = 0; tick(2);
    chk_codes("R2 sync latency");
    tick(1);
    for (int i = 0; i < NCH; i++) exp_c[i] = pat(i, 0);
    chk_codes("R2 pin load");
    load_n = 1; tick(3);

    // R4 only written channel changes
    wr_dat(3, 12'hABC); tick(2);
    load_n = 0; tick(4); load_n = 1; tick(3);
    exp_c[3] = 12'hABC;
    chk_codes("R4 single pending channel");

    // R4 write coinciding with load event (pin held low)
    load_n = 0; tick(4);
    wr_dat(2, 12'h5A5);
    chk_codes("R4 same-cycle write not yet");
    tick(1);
    exp_c[2] = 12'h5A5;
    chk_codes("R4 same-cycle write next edge");
    load_n = 1; tick(3);

    // R3 one-shot
    wr_dat(6, 12'h123); tick(1);
    wr_mode(2'b10); tick(1);
    exp_c[6] = 12'h123;
    chk_codes("R3 one-shot transfer");
    wr_dat(6, 12'h321); tick(4);
    chk_codes("R3 one-shot then latched");

    // R3 reserved code ignored (stays latched)
    wr_mode(2'b11);
    wr_dat(5, 12'hFFF); tick(4);
    chk_codes("R3 reserved ignored");

    // R3 transparent sweep, every channel
    wr_mode(2'b00); tick(1);
    exp_c[6] = 12'h321; exp_c[5] = 12'hFFF;
    chk_codes("R3 transparent flushes pending");
    for (int k = 1; k < 5; k++)
      for (int i = 0; i < NCH; i++) begin
        wr_dat(i, pat(i, k)); tick(1);
        exp_c[i] = pat(i, k);
        chk_codes("R1 transparent sweep");
      end

    // R5/R6 configuration sweep in transparent mode
    for (int v = 0; v < 64; v++) begin
      logic [1:0] g, b, s;
      g = v[1:0]; b = v[3:2]; s = v[5:4];
      wr_cfg(g, b, s); tick(1);
      chk({eff_gain, eff_buf, eff_sup} == {g & ~s, b & ~s, s}, "R6 effective config",
          {eff_gain, eff_buf, eff_sup}, {g & ~s, b & ~s, s});
    end

    // R5 config staged in latched mode
    wr_mode(2'b01);
    wr_cfg(2'b11, 2'b11, 2'b00); tick(4);
    chk({eff_gain, eff_buf, eff_sup} == 6'b000011, "R5 config held", {eff_gain, eff_buf, eff_sup}, 6'b000011);
    load_n = 0; tick(4); load_n = 1; tick(3);
    chk({eff_gain, eff_buf, eff_sup} == 6'b111100, "R5 config on load", {eff_gain, eff_buf, eff_sup}, 6'b111100);

    // R7 power-down
    pd_wr = 1; pd_val = 8'hA5; tick(1); pd_wr = 0;
    chk(pd_out == 8'hA5, "R7 power-down mask", pd_out, 8'hA5);
    wr_mode(2'b00);
    wr_dat(0, 12'h777); tick(1);
    exp_c[0] = 12'h777;
    chk_codes("R7 write while powered down");
    pd_wr = 1; pd_val = 8'h3C; tick(1); pd_wr = 0;
    chk(pd_out == 8'h3C, "R7 mask rewrite", pd_out, 8'h3C);

    // R8 data reset keeps control
    clr_data = 1; tick(1); clr_data = 0;
    for (int i = 0; i < NCH; i++) exp_c[i] = '0;
    chk_codes("R8 data reset codes");
    chk({eff_gain, eff_buf, pd_out} == {2'b11, 2'b11, 8'h3C}, "R8 control kept",
        {eff_gain, eff_buf, pd_out}, {2'b11, 2'b11, 8'h3C});

    // R9 full reset
    wr_dat(4, 12'h0F0); tick(1);
    clr_all = 1; tick(1); clr_all = 0;
    chk_codes("R9 full reset codes");
    chk({eff_gain, eff_buf, eff_sup, pd_out} == '0, "R9 full reset control",
        {eff_gain, eff_buf, eff_sup, pd_out}, 0);
    wr_dat(4, 12'h0F0); tick(4);
    chk_codes("R9 latched after full reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule